// File: doc/BRIEF.md
# Standby Mode Controller for a Serial Bus Node

This block governs two low-power standby levels of a serial bus controller. A host write to a two-bit standby request field asks for either a light standby (sleep) or a deep standby (stop). The request is held until the bus reports idle. Only then does the block move into the requested level. While in a standby level, the block drops the enables it drives to the core clock gate and, for the deep level, to the oscillator.

The two levels differ in what wakes them. The light level returns to normal operation when either leg of the differential receive pair goes low, or when the external reset pin or the chip-select pin goes low. The deep level ignores receive-line activity and wakes only on the reset or chip-select pin. All four wake pins are asynchronous. Each passes through a flop synchronizer before use. Any wake-up clears the pending request, so the node stays in normal operation until the host asks again.

`rst_n` is the synchronous system reset of the block. `pin_reset_n` is the sampled external reset pin, and the block treats it only as a wake source.

Top module: `lps_standby_ctrl`

## Requirements
- R1: After `rst_n` is held low, `mode` is 2'b00 (normal), `core_clk_en` is 1 and `osc_en` is 1. `mode` never takes the value 2'b11.
- R2: A write with `cfg_wdata` bit 0 = 1 and bit 1 = 0 requests sleep. Sleep (`mode` = 2'b01) is entered only in a cycle where `bus_idle` is 1.
- R3: A write with `cfg_wdata` bit 1 = 1 requests stop (`mode` = 2'b10). When both bits are 1, stop is entered. Sleep never changes directly into stop.
- R4: A request made while `bus_idle` is 0 stays pending. Writing 2'b00 in normal mode cancels it, and no standby level is entered afterwards.
- R5: In sleep, a low level on `rxd_p`, `rxd_n`, `pin_reset_n` or `pin_cs_n` returns `mode` to 2'b00.
- R6: In stop, low levels on `rxd_p` or `rxd_n` leave `mode` at 2'b10. A low on `pin_reset_n` or `pin_cs_n` returns it to 2'b00.
- R7: A wake-up clears the pending request. With `bus_idle` = 1 afterwards, `mode` stays 2'b00.
- R8: Writes made while in a standby level are ignored.
- R9: Entry is held off while a wake source of the target level is low. For example, a low `pin_cs_n` blocks entry, and entry follows once the pin is high again.
- R10: `core_clk_en` is 0 in both sleep and stop. `osc_en` is 0 only in stop.
- R11: With the default two synchronizer stages, a wake pin that falls before a rising edge changes `mode` on the third rising edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cfg_wr | input | 1 | Standby request write strobe |
| cfg_wdata | input | 2 | Request data: bit 0 sleep, bit 1 stop |
| bus_idle | input | 1 | Bus idle indication, synchronous to clk |
| rxd_p | input | 1 | Receive pair, positive leg (asynchronous) |
| rxd_n | input | 1 | Receive pair, negative leg (asynchronous) |
| pin_reset_n | input | 1 | External reset pin used as wake source (asynchronous) |
| pin_cs_n | input | 1 | Chip-select pin used as wake source (asynchronous) |
| mode | output | 2 | Current level: 00 normal, 01 sleep, 10 stop |
| core_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The hardest case to reach from the ports is a request whose entry is blocked by a wake source of the target level. This needs a pending request, an idle bus and a chip-select held low, all at the same time. The bench holds `pin_cs_n` low before writing the request, raises the bus idle flag, and confirms that the mode does not move. It then releases the pin and watches entry follow through the synchronizer delay. A second hard case is a write arriving during standby. It is shown to be ignored by waking the node and then keeping the bus idle, which proves no stop request survived.

// File: rtl/lps_pkg.sv
// Shared constants and the mode encoding of the standby controller.
// Assumes at most two request bits and four wake pins.
package lps_pkg;
    localparam int REQ_W     = 2;
    localparam int REQ_SLEEP = 0;
    localparam int REQ_STOP  = 1;
    localparam int WAKE_N    = 4;
    localparam int WK_RXP    = 0;
    localparam int WK_RXN    = 1;
    localparam int WK_RST    = 2;
    localparam int WK_CS     = 3;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_STOP  = 2'b10
    } lps_mode_e;
endpackage

// File: rtl/lps_wake_sync.sv
// Per-bit flop-chain synchronizer for asynchronous active-low wake pins.
// Assumes STAGES >= 2; chains reset to the inactive (high) level.
module lps_wake_sync #(
    parameter int N_IN   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] async_in,
    output logic [N_IN-1:0] sync_out
);
    for (genvar b = 0; b < N_IN; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin level through the chain, inactive during reset.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/lps_req_reg.sv
// Holds the host standby request until a wake-up clears it.
// Assumes the caller qualifies wr_en so writes during standby are dropped.
module lps_req_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] req
);
    // Wake clear has priority over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)     req <= '0;
        else if (clr)   req <= '0;
        else if (wr_en) req <= wdata;
    end
endmodule

// File: rtl/lps_mode_fsm.sv
// Mode state machine: enters the requested level on bus idle, leaves on wake.
// Assumes soft_wake and hard_wake are already synchronous to clk.
module lps_mode_fsm
    import lps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] req,
    input  logic             bus_idle,
    input  logic             soft_wake,
    input  logic             hard_wake,
    output lps_mode_e        mode_q,
    output logic             wake_evt
);
    lps_mode_e target;
    logic      entry_ok;

    // Choose the level to enter; stop wins over sleep.
    always_comb begin
        target = req[REQ_STOP] ? MODE_STOP : MODE_SLEEP;
    end

    // Entry needs a request, an idle bus and no active wake source of the target.
    always_comb begin
        entry_ok = (|req) && bus_idle && !hard_wake
                   && !((target == MODE_SLEEP) && soft_wake);
    end

    // Wake condition depends on the level currently held.
    always_comb begin
        wake_evt = ((mode_q == MODE_SLEEP) && (soft_wake || hard_wake))
                || ((mode_q == MODE_STOP)  && hard_wake);
    end

    // Mode register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
        end else begin
            case (mode_q)
                MODE_RUN:   if (entry_ok) mode_q <= target;
                MODE_SLEEP,
                MODE_STOP:  if (wake_evt) mode_q <= MODE_RUN;
                default:    mode_q <= MODE_RUN;
            endcase
        end
    end
endmodule

// File: rtl/lps_standby_ctrl.sv
// Top of the standby controller: synchronizes wake pins, holds the request,
// runs the mode machine and drives the clock and oscillator enables.
// Assumes clk keeps running in every level; bus_idle is synchronous to clk.
module lps_standby_ctrl
    import lps_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_wdata,
    input  logic       bus_idle,
    input  logic       rxd_p,
    input  logic       rxd_n,
    input  logic       pin_reset_n,
    input  logic       pin_cs_n,
    output logic [1:0] mode,
    output logic       core_clk_en,
    output logic       osc_en
);
    logic [WAKE_N-1:0] raw_w;
    logic [WAKE_N-1:0] sync_w;
    logic [REQ_W-1:0]  req_q;
    lps_mode_e         mode_q;
    logic              wake_evt;
    logic              in_run;
    logic              soft_wake;
    logic              hard_wake;

    assign raw_w = {pin_cs_n, pin_reset_n, rxd_n, rxd_p};

    lps_wake_sync #(.N_IN(WAKE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_w),
        .sync_out (sync_w)
    );

    // Receive activity wakes only the light level; the pins wake both.
    always_comb begin
        soft_wake = !sync_w[WK_RXP] || !sync_w[WK_RXN];
        hard_wake = !sync_w[WK_RST] || !sync_w[WK_CS];
    end

    assign in_run = (mode_q == MODE_RUN);

    lps_req_reg #(.W(REQ_W)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr && in_run),
        .wdata (cfg_wdata),
        .clr   (wake_evt),
        .req   (req_q)
    );

    lps_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_q),
        .bus_idle  (bus_idle),
        .soft_wake (soft_wake),
        .hard_wake (hard_wake),
        .mode_q    (mode_q),
        .wake_evt  (wake_evt)
    );

    // Output decode of the mode register.
    always_comb begin
        mode        = mode_q;
        core_clk_en = in_run;
        osc_en      = (mode_q != MODE_STOP);
    end
endmodule

// File: rtl/lps_standby_chk.sv
// Property checker for the standby controller, attached by bind.
module lps_standby_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_idle,
    input logic [1:0] mode,
    input logic [1:0] req,
    input logic       core_clk_en,
    input logic       osc_en,
    input logic       hard_wake
);
    p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    p_entry_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && $past(mode) == 2'b00) |-> $past(bus_idle));

    p_no_sleep_to_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (mode != 2'b10));

    p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !hard_wake) |=> (mode == 2'b10));

    p_stop_exit_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10 && mode == 2'b00) |-> $past(hard_wake));

    p_wake_clears_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) != 2'b00 && mode == 2'b00) |-> (req == 2'b00));

    p_gate_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !core_clk_en);
endmodule

bind lps_standby_ctrl lps_standby_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_idle    (bus_idle),
    .mode        (mode),
    .req         (req_q),
    .core_clk_en (core_clk_en),
    .osc_en      (osc_en),
    .hard_wake   (hard_wake)
);

// File: tb/tb_lps_standby_ctrl.sv
module tb_lps_standby_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cfg_wr = 0;
    logic [1:0] cfg_wdata = 0;
    logic       bus_idle = 0;
    logic       rxd_p = 1, rxd_n = 1, pin_reset_n = 1, pin_cs_n = 1;
    logic [1:0] mode;
    logic       core_clk_en, osc_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lps_standby_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .bus_idle(bus_idle), .rxd_p(rxd_p), .rxd_n(rxd_n),
        .pin_reset_n(pin_reset_n), .pin_cs_n(pin_cs_n),
        .mode(mode), .core_clk_en(core_clk_en), .osc_en(osc_en)
    );

    // Vector: {write data[4:3], bus idle[2], expected mode[1:0]}
    localparam logic [4:0] VECS [0:4] = '{
        5'b01_1_01,   // R2 sleep on idle bus
        5'b10_1_10,   // R3 stop
        5'b11_1_10,   // R3 both bits: stop wins
        5'b01_0_00,   // R4 bus busy: stays pending
        5'b00_1_00    // no request
    };

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] d);
        @(negedge clk); cfg_wr = 1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic chk(string rq, logic [1:0] exp_m);
        logic ec, eo;
        ec = (exp_m == 2'b00);
        eo = (exp_m != 2'b10);
        total++;
        if (mode !== exp_m || core_clk_en !== ec || osc_en !== eo) begin
            bad++;
            $display("FAIL %s: mode=%b clk_en=%b osc_en=%b expected mode=%b clk_en=%b osc_en=%b",
                     rq, mode, core_clk_en, osc_en, exp_m, ec, eo);
        end
    endtask

    task automatic cs_pulse();
        pin_cs_n = 0; tick(4);
        pin_cs_n = 1; tick(4);
    endtask

    initial begin
        tick(5);
        chk("R1 reset", 2'b00);
        rst_n = 1;
        tick(2);
        chk("R1 after release", 2'b00);

        // Table walk: request, check level, cancel, wake, confirm normal.
        for (int i = 0; i < 5; i++) begin
            bus_idle = VECS[i][2];
            wr(VECS[i][4:3]);
            tick(3);
            chk("R2 R3 R4 R10 table entry", VECS[i][1:0]);
            wr(2'b00);
            bus_idle = 1;
            cs_pulse();
            tick(3);
            chk("R4 R5 R7 table return", 2'b00);
        end

        // R11 exact synchronizer latency, rxd_p waking sleep.
        bus_idle = 1;
        wr(2'b01); tick(3);
        chk("R2 sleep before R11", 2'b01);
        @(negedge clk); rxd_p = 0;
        tick(2);
        chk("R11 still asleep after two edges", 2'b01);
        tick(1);
        chk("R11 awake on third edge", 2'b00);
        rxd_p = 1; tick(4);

        // R5 rxd_n wakes sleep; R8 write during sleep ignored.
        wr(2'b01); tick(3);
        chk("R5 sleep", 2'b01);
        wr(2'b10); tick(3);
        chk("R8 write in sleep ignored", 2'b01);
        rxd_n = 0; tick(4);
        chk("R5 rxd_n wake", 2'b00);
        rxd_n = 1; tick(6);
        chk("R7 R8 no re-entry after wake", 2'b00);

        // R5 reset pin wakes sleep.
        wr(2'b01); tick(3);
        pin_reset_n = 0; tick(4);
        chk("R5 reset pin wakes sleep", 2'b00);
        pin_reset_n = 1; tick(4);

        // R6 stop ignores receive lines, wakes on reset pin.
        wr(2'b10); tick(3);
        chk("R6 stop entered", 2'b10);
        rxd_p = 0; rxd_n = 0; tick(6);
        chk("R6 rx ignored in stop", 2'b10);
        rxd_p = 1; rxd_n = 1; tick(4);
        pin_reset_n = 0; tick(4);
        chk("R6 reset pin wakes stop", 2'b00);
        pin_reset_n = 1; tick(4);

        // R4 cancel while bus busy, then idle.
        bus_idle = 0;
        wr(2'b10); tick(3);
        chk("R4 pending while busy", 2'b00);
        wr(2'b00);
        bus_idle = 1; tick(4);
        chk("R4 cancelled", 2'b00);

        // R9 chip select low blocks entry, release lets it proceed.
        pin_cs_n = 0; tick(4);
        wr(2'b01); tick(6);
        chk("R9 entry blocked by cs", 2'b00);
        pin_cs_n = 1; tick(5);
        chk("R9 entry after cs release", 2'b01);
        cs_pulse();
        chk("R5 cs wakes sleep", 2'b00);

        // R9 receive low blocks sleep entry but not stop entry.
        rxd_p = 0; tick(4);
        wr(2'b01); tick(4);
        chk("R9 rx blocks sleep entry", 2'b00);
        wr(2'b10); tick(3);
        chk("R9 rx does not block stop", 2'b10);
        rxd_p = 1; tick(3);
        cs_pulse();
        chk("R6 cs wakes stop", 2'b00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule